// File: doc/BRIEF.md
# Byte-Wide Asynchronous Configuration Load Port

This block lets an external processor push configuration bytes into a device over a simple asynchronous bus. The processor selects the port with a pair of chip selects of opposite polarity, presents a byte and pulls the write strobe low. The port brings the strobe into the internal clock domain and captures the byte once per strobe. It then hands the byte to an internal consumer over a valid/data interface.

While the consumer has not taken the byte, the port reports busy on its ready output. It refuses further bytes and records any attempt to write one as a sticky overrun. The processor can also poll the port. A read strobe makes the port drive a five-bit status word on the upper bus lanes, and the ready flag appears on the top lane. The bidirectional bus is modelled as separate input, output and per-bit output-enable vectors.

Top module: `cfg_byte_port`

## Requirements
- R1: The port is selected only while `cs_lo_n` is 0 and `cs_hi` is 1. When not selected, it captures nothing, its consumer-side state stays unchanged, and `bus_oe` is all zeros.
- R2: A selected write (`wr_n` low) is captured at the third rising clock edge after the strobe falls (two synchronizer flops plus the capture register). At that edge `byte_vld` rises and `byte_data` takes the value on `bus_in`.
- R3: A single low period of the write strobe captures at most one byte, however long it lasts.
- R4: While selected with `rd_n` low and `wr_n` high, `bus_oe` is 8'hF8 without any clock delay: lanes 7..3 are driven and lanes 2..0 are left undriven.
- R5: If `rd_n` and `wr_n` are both low while selected, the write is captured as in R2, and `bus_oe` stays all zeros.
- R6: `rdy` is 1 when idle. It goes to 0 at the capture edge and stays 0 until a rising edge with `byte_taken` high, after which it is 1 again. `byte_vld` is always the inverse of `rdy`.
- R7: During a status read, lane 7 of `bus_out` equals `rdy`.
- R8: During a status read, lane 6 is the overrun flag, lane 5 mirrors the `cfg_done` input, and lanes 4 and 3 are 0.
- R9: A selected write captured while busy is dropped: `byte_data` and `byte_vld` do not change. The overrun flag is set and stays set until reset.
- R10: After synchronous reset, `rdy` is 1, `byte_vld` is 0 and the overrun flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_lo_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| bus_in | input | 8 | Bus value seen at the pads |
| bus_out | output | 8 | Value the port drives onto the bus |
| bus_oe | output | 8 | Per-lane output enable |
| cfg_done | input | 1 | Done flag from the configuration logic |
| rdy | output | 1 | High when another byte may be written |
| byte_vld | output | 1 | Captured byte is waiting for the consumer |
| byte_data | output | 8 | Captured byte |
| byte_taken | input | 1 | Consumer has taken the byte |

## Verification
A write takes effect at the third rising edge after the bus drives the strobe low. The bench applies every stimulus on a falling edge and checks that `byte_vld` is still low one half-cycle after the second rising edge, then checks the captured byte and `rdy` half a cycle after the third. The read path is combinational, so status and enables are checked one time unit after the read strobe is applied, with no clock edge in between. An acknowledge frees the port at the next rising edge and is checked on the falling edge that follows. After each strobe is released, the bench waits for the synchronizer to drain before the next transaction, so no expectation depends on overlapping strobes.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    localparam int BYTE_W   = 8;
    localparam int STAT_W   = 5;
    localparam int STAT_LSB = BYTE_W - STAT_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } bus_op_e;

    typedef struct packed {
        logic       ready;
        logic       overrun;
        logic       done;
        logic [1:0] spare;
    } stat_t;

    function automatic logic is_selected(logic cs_lo_n, logic cs_hi);
        return !cs_lo_n && cs_hi;
    endfunction

    // Write strobe wins whenever both strobes are active.
    function automatic bus_op_e decode_op(logic cs_lo_n, logic cs_hi,
                                          logic rd_n, logic wr_n);
        if (!is_selected(cs_lo_n, cs_hi)) return OP_IDLE;
        if (!wr_n)                        return OP_WRITE;
        if (!rd_n)                        return OP_READ;
        return OP_IDLE;
    endfunction

    function automatic stat_t make_stat(logic ready, logic overrun, logic done);
        stat_t s;
        s.ready   = ready;
        s.overrun = overrun;
        s.done    = done;
        s.spare   = '0;
        return s;
    endfunction

endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise_o = chain_q[STAGES-1] && !last_q;
endmodule

// File: rtl/cfgp_capture.sv
module cfgp_capture
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              ack_i,
    output logic              busy_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              ovr_o
);
    logic              busy_q;
    logic              ovr_q;
    logic [BYTE_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ovr_q  <= 1'b0;
            data_q <= '0;
        end else begin
            if (take_i && !busy_q) begin
                busy_q <= 1'b1;
                data_q <= data_i;
            end else if (busy_q && ack_i) begin
                busy_q <= 1'b0;
            end
            if (take_i && busy_q) ovr_q <= 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign data_o = data_q;
    assign ovr_o  = ovr_q;
endmodule

// File: rtl/cfgp_status_drv.sv
module cfgp_status_drv
    import cfgp_pkg::*;
(
    input  bus_op_e           op_i,
    input  stat_t             stat_i,
    output logic [BYTE_W-1:0] bus_o,
    output logic [BYTE_W-1:0] oe_o
);
    always_comb begin
        bus_o = '0;
        oe_o  = '0;
        if (op_i == OP_READ) begin
            bus_o[BYTE_W-1:STAT_LSB] = stat_i;
            oe_o[BYTE_W-1:STAT_LSB]  = '1;
        end
    end
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
    import cfgp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_lo_n,
    input  logic              cs_hi,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] bus_out,
    output logic [BYTE_W-1:0] bus_oe,
    input  logic              cfg_done,
    output logic              rdy,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_taken
);
    bus_op_e op;
    logic    wr_req;
    logic    wr_rise;
    logic    busy;
    logic    ovr_q;
    stat_t   stat;

    assign op     = decode_op(cs_lo_n, cs_hi, rd_n, wr_n);
    assign wr_req = (op == OP_WRITE);

    cfgp_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (wr_req),
        .rise_o  (wr_rise)
    );

    cfgp_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .take_i (wr_rise),
        .data_i (bus_in),
        .ack_i  (byte_taken),
        .busy_o (busy),
        .data_o (byte_data),
        .ovr_o  (ovr_q)
    );

    assign stat = make_stat(!busy, ovr_q, cfg_done);

    cfgp_status_drv u_stat (
        .op_i   (op),
        .stat_i (stat),
        .bus_o  (bus_out),
        .oe_o   (bus_oe)
    );

    assign rdy      = !busy;
    assign byte_vld = busy;
endmodule

// File: rtl/cfg_byte_port_chk.sv
module cfg_byte_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_lo_n,
    input logic       cs_hi,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] bus_out,
    input logic [7:0] bus_oe,
    input logic       rdy,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       byte_taken,
    input logic       ovr_q
);
    AST_IDLE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        !(!cs_lo_n && cs_hi) |-> bus_oe == 8'h00); // R1
    AST_LOW_LANES_FREE: assert property (@(posedge clk) disable iff (rst)
        bus_oe[2:0] == 3'b000); // R4
    AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !rd_n) |-> bus_oe == 8'h00); // R5
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rdy && !byte_taken) |=> !rdy); // R6
    AST_ACK_FREES: assert property (@(posedge clk) disable iff (rst)
        (!rdy && byte_taken) |=> rdy); // R6
    AST_VLD_INVERSE: assert property (@(posedge clk) disable iff (rst)
        byte_vld == !rdy); // R6
    AST_READY_LANE: assert property (@(posedge clk) disable iff (rst)
        bus_oe[7] |-> bus_out[7] == rdy); // R7
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_oe[4] |-> bus_out[4:3] == 2'b00); // R8
    AST_HELD_BYTE: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && $past(byte_vld)) |-> $stable(byte_data)); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q); // R9
endmodule

bind cfg_byte_port cfg_byte_port_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_lo_n    (cs_lo_n),
    .cs_hi      (cs_hi),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .rdy        (rdy),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .byte_taken (byte_taken),
    .ovr_q      (ovr_q)
);

// File: tb/cfg_byte_port_tb.sv
`timescale 1ns/1ps
module cfg_byte_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_lo_n = 1'b1, cs_hi = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out, bus_oe, byte_data;
    logic       cfg_done = 1'b0, rdy, byte_vld, byte_taken = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit exp_busy = 0, exp_ovr = 0;
    logic [7:0] exp_data = 8'h00;

    always #4 clk = ~clk;

    cfg_byte_port u_dut (
        .clk(clk), .rst(rst), .cs_lo_n(cs_lo_n), .cs_hi(cs_hi),
        .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .cfg_done(cfg_done), .rdy(rdy), .byte_vld(byte_vld),
        .byte_data(byte_data), .byte_taken(byte_taken)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] exp_stat(input bit busy, input bit ovr, input bit dn);
        return {~busy, ovr, dn, 2'b00, 3'b000};
    endfunction

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic release_bus;
        @(negedge clk);
        wr_n = 1'b1; rd_n = 1'b1; cs_lo_n = 1'b1; cs_hi = 1'b0;
        settle(4);
    endtask

    task automatic do_write(input logic [7:0] b, input bit lo_n, input bit hi, input bit with_rd);
        bit sel = !lo_n && hi;
        @(negedge clk);
        cs_lo_n = lo_n; cs_hi = hi; bus_in = b; wr_n = 1'b0; rd_n = !with_rd;
        #1;
        if (with_rd) check(bus_oe == 8'h00, "R5 write overrides read", bus_oe, 0);
        if (!sel) check(bus_oe == 8'h00, "R1 unselected undriven", bus_oe, 0);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(byte_vld == exp_busy, "R2 no capture before third edge", byte_vld, exp_busy);
        @(negedge clk);
        if (sel) begin
            if (exp_busy) exp_ovr = 1;
            else begin exp_busy = 1; exp_data = b; end
        end
        check(byte_vld == exp_busy, "R2/R9 valid after capture", byte_vld, exp_busy);
        check(byte_data == exp_data, "R2/R9 captured byte", byte_data, exp_data);
        check(rdy == !exp_busy, "R6 ready after capture", rdy, !exp_busy);
        release_bus();
    endtask

    task automatic do_ack;
        @(negedge clk); byte_taken = 1'b1;
        @(negedge clk); byte_taken = 1'b0;
        exp_busy = 0;
        check(rdy == 1'b1, "R6 ready after taken", rdy, 1);
        check(byte_vld == 1'b0, "R6 valid drops", byte_vld, 0);
    endtask

    task automatic do_read(input bit lo_n, input bit hi);
        @(negedge clk);
        cs_lo_n = lo_n; cs_hi = hi; rd_n = 1'b0; wr_n = 1'b1;
        #1;
        if (!lo_n && hi) begin
            check(bus_oe == 8'hF8, "R4 status lanes enabled", bus_oe, 8'hF8);
            check(bus_out[7] == rdy, "R7 ready on lane 7", bus_out[7], rdy);
            check((bus_out & 8'hF8) == exp_stat(exp_busy, exp_ovr, cfg_done),
                  "R8 status word", bus_out & 8'hF8, exp_stat(exp_busy, exp_ovr, cfg_done));
        end else begin
            check(bus_oe == 8'h00, "R1 read ignored unselected", bus_oe, 0);
        end
        release_bus();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd1234));
        settle(3);
        @(negedge clk); rst = 1'b0;
        check(rdy == 1'b1, "R10 reset ready", rdy, 1);
        check(byte_vld == 1'b0, "R10 reset valid", byte_vld, 0);
        do_read(1'b0, 1'b1);

        do_write(8'hA5, 1'b0, 1'b1, 1'b0);
        do_read(1'b0, 1'b1);
        do_ack();
        do_write(8'h3C, 1'b1, 1'b1, 1'b0);   // R1 wrong low select
        do_write(8'h3C, 1'b0, 1'b0, 1'b0);   // R1 wrong high select
        do_read(1'b1, 1'b0);
        do_write(8'h5A, 1'b0, 1'b1, 1'b1);   // R5
        do_write(8'hFF, 1'b0, 1'b1, 1'b0);   // R9 overrun
        cfg_done = 1'b1;
        do_read(1'b0, 1'b1);
        do_ack();
        do_read(1'b0, 1'b1);                 // R9 flag sticky

        // R3: long strobe, acknowledge while still low, no second capture
        @(negedge clk); cs_lo_n = 1'b0; cs_hi = 1'b1; bus_in = 8'h81; wr_n = 1'b0;
        settle(4);
        check(byte_data == 8'h81, "R3 first capture", byte_data, 8'h81);
        @(negedge clk); byte_taken = 1'b1;
        @(negedge clk); byte_taken = 1'b0;
        settle(6);
        check(byte_vld == 1'b0, "R3 single capture per strobe", byte_vld, 0);
        exp_busy = 0; exp_data = 8'h81;
        release_bus();

        for (int k = 0; k < 60; k++) begin
            int sel_pick = $urandom_range(0, 5);
            bit lo = (sel_pick == 0);
            bit hi = (sel_pick != 1);
            if ($urandom_range(0, 3) == 0) cfg_done = ~cfg_done;
            case ($urandom_range(0, 3))
                0, 1: do_write(8'($urandom), lo, hi, $urandom_range(0, 3) == 0);
                2:    do_read(lo, hi);
                default: if (exp_busy) do_ack();
            endcase
        end

        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        exp_busy = 0; exp_ovr = 0;
        check(rdy == 1'b1, "R10 ready after reset", rdy, 1);
        do_read(1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule